// File: doc/BRIEF.md
# Console Terminal Receive/Transmit Interface

This block sits between a processor's register-access path and a byte-wide character source and sink, for example a UART. Software reaches it through four register slots: receive status, receive data, transmit status and transmit data. Each status slot holds a completion flag (DONE) and an interrupt enable (IE). The block drives one interrupt request for each direction.

An incoming character is captured into an 8-bit holding register and marks receive DONE. Reading the receive data slot returns the character and clears DONE and the request. Writing the transmit data slot captures a character, clears transmit DONE and starts a send. The send waits a programmable number of cycles and then offers the low 7 bits on the sink port. DONE returns once the sink takes the character.

Both byte ports are valid/ready. The receive side is always ready once it leaves reset, so a source never stalls. The transmit side holds `tx_valid` and `tx_data` steady until `tx_ready` is seen. The only exception is a new transmit data write, which withdraws the pending character and restarts the send.

Top module: `console_term`

## Requirements
- R1: `reg_sel` picks the slot: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data. `reg_rdata` follows `reg_sel` combinationally. A status byte reads DONE at bit 7 and IE at bit 6, with bits 5..0 reading 0. The transmit data slot reads 0. A status write changes only IE, taken from `reg_wdata[6]`. A write to the receive data slot has no effect.
- R2: Writing IE=0 to a status slot drops that direction's request. Writing IE=1 while DONE=1 and IE was 0 raises it. Writing IE=1 while IE is already 1 leaves the request unchanged.
- R3: `rx_ready` is low in reset and high from the first clock after reset. A handshake stores `rx_data` and sets receive DONE. It also raises `irq_rx` if IE is set, using IE as written in that same cycle.
- R4: A character that arrives while receive DONE is set replaces the stored one. No other state changes.
- R5: A read (`reg_rd`) of the receive data slot returns the stored byte and clears receive DONE and `irq_rx` on the next edge. If a character arrives in the same cycle, the arrival wins: DONE stays set and the new byte is stored.
- R6: A write to the transmit data slot stores the byte and clears transmit DONE and `irq_tx`. After `send_delay`+1 clock edges, `tx_valid` rises with `tx_data` equal to the low 7 bits of that byte.
- R7: While `tx_ready` is low, `tx_valid` and `tx_data` hold. On the handshake edge `tx_valid` falls and transmit DONE sets, raising `irq_tx` if IE is set.
- R8: A transmit data write during a wait or a pending offer drops the old character and `tx_valid`, then restarts the send with the new byte and delay. If it coincides with a handshake, the write wins and DONE stays clear.
- R9: Reset (`rst_n` low, asynchronous) does the following:
  - clears the receive buffer;
  - sets receive status to 0x00 and transmit status to 0x80;
  - drops both requests and `tx_valid`;
  - cancels any send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register slot select |
| reg_rd | input | 1 | Read strobe (side effect on receive data slot) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected slot |
| send_delay | input | DLY_W | Wait cycles before a character is offered |
| rx_valid | input | 1 | Source has a character |
| rx_data | input | 8 | Source character |
| rx_ready | output | 1 | Block accepts a character |
| tx_valid | output | 1 | Character offered to sink |
| tx_data | output | 7 | Offered character, low 7 bits |
| tx_ready | input | 1 | Sink accepts the character |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with `DLY_W` = 4. This makes the full delay range 0..15 cheap to cover, so both the zero-wait corner and the all-ones maximum are exercised in a short run. With short waits, a restart can land during the wait and again during a stalled offer, and a handshake can coincide with a fresh write. A small delay width also keeps overwrites, same-cycle read-and-arrival and mid-run resets within a few hundred cycles.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_IE_BIT   = 6;
  localparam int CHAR_W        = 8;
  localparam int OUT_W         = 7;

  typedef enum logic [1:0] {
    SEL_RX_STAT = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_STAT = 2'd2,
    SEL_TX_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_OFFER = 2'd2
  } tx_state_e;
endpackage

// File: rtl/con_flag_ctl.sv
// DONE / IE / interrupt-request trio shared by both directions.
module con_flag_ctl #(
  parameter bit DONE_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic ie_wdata,
  input  logic done_set,
  input  logic done_clr,
  output logic done_q,
  output logic ie_q,
  output logic irq_q
);
  logic ie_n, irq_n, done_n;

  always_comb begin
    ie_n  = csr_wr ? ie_wdata : ie_q;
    irq_n = irq_q;
    if (done_clr) irq_n = 1'b0;
    if (csr_wr) begin
      if (!ie_wdata)            irq_n = 1'b0;
      else if (!ie_q && done_q) irq_n = 1'b1;
    end
    if (done_set && ie_n) irq_n = 1'b1;
    done_n = done_set ? 1'b1 : (done_clr ? 1'b0 : done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= DONE_AT_RESET;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/con_rx_chan.sv
module con_rx_chan
  import con_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_data,
  output logic              src_ready,
  output logic              accept,
  output logic [CHAR_W-1:0] hold_q
);
  assign accept = src_valid && src_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ready <= 1'b0;
      hold_q    <= '0;
    end else begin
      src_ready <= 1'b1;
      if (accept) hold_q <= src_data;
    end
  end
endmodule

// File: rtl/con_tx_chan.sv
module con_tx_chan
  import con_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] load_char,
  input  logic [DLY_W-1:0] load_delay,
  input  logic             snk_ready,
  output logic             snk_valid,
  output logic [OUT_W-1:0] snk_data,
  output logic             sent
);
  tx_state_e        state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [OUT_W-1:0] char_q;   // bit 7 is never emitted nor read back

  assign snk_valid = (state_q == TX_OFFER);
  assign snk_data  = char_q;
  assign sent      = snk_valid && snk_ready && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      char_q  <= '0;
    end else if (load) begin
      state_q <= TX_WAIT;
      cnt_q   <= load_delay;
      char_q  <= load_char;
    end else begin
      case (state_q)
        TX_WAIT:  if (cnt_q == '0) state_q <= TX_OFFER;
                  else cnt_q <= cnt_q - 1'b1;
        TX_OFFER: if (snk_ready) state_q <= TX_IDLE;
        default:  state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/console_term.sv
module console_term
  import con_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [DLY_W-1:0] send_delay,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [6:0]       tx_data,
  input  logic             tx_ready,
  output logic             irq_rx,
  output logic             irq_tx
);
  reg_sel_e    sel;
  logic        wr_rx_stat, rd_rx_data, wr_tx_stat, wr_tx_data;
  logic        rx_accept, tx_sent;
  logic        rx_done, rx_ie, tx_done, tx_ie;
  logic [7:0]  rx_hold;

  assign sel        = reg_sel_e'(reg_sel);
  assign wr_rx_stat = reg_wr && (sel == SEL_RX_STAT);
  assign rd_rx_data = reg_rd && (sel == SEL_RX_DATA);
  assign wr_tx_stat = reg_wr && (sel == SEL_TX_STAT);
  assign wr_tx_data = reg_wr && (sel == SEL_TX_DATA);

  con_rx_chan u_rx (
    .clk(clk), .rst_n(rst_n),
    .src_valid(rx_valid), .src_data(rx_data), .src_ready(rx_ready),
    .accept(rx_accept), .hold_q(rx_hold)
  );

  con_tx_chan #(.DLY_W(DLY_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(wr_tx_data), .load_char(reg_wdata[OUT_W-1:0]), .load_delay(send_delay),
    .snk_ready(tx_ready), .snk_valid(tx_valid), .snk_data(tx_data),
    .sent(tx_sent)
  );

  con_flag_ctl #(.DONE_AT_RESET(1'b0)) u_rx_flags (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(wr_rx_stat), .ie_wdata(reg_wdata[STAT_IE_BIT]),
    .done_set(rx_accept), .done_clr(rd_rx_data),
    .done_q(rx_done), .ie_q(rx_ie), .irq_q(irq_rx)
  );

  con_flag_ctl #(.DONE_AT_RESET(1'b1)) u_tx_flags (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(wr_tx_stat), .ie_wdata(reg_wdata[STAT_IE_BIT]),
    .done_set(tx_sent), .done_clr(wr_tx_data),
    .done_q(tx_done), .ie_q(tx_ie), .irq_q(irq_tx)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_RX_STAT: begin
        reg_rdata[STAT_DONE_BIT] = rx_done;
        reg_rdata[STAT_IE_BIT]   = rx_ie;
      end
      SEL_RX_DATA: reg_rdata = rx_hold;
      SEL_TX_STAT: begin
        reg_rdata[STAT_DONE_BIT] = tx_done;
        reg_rdata[STAT_IE_BIT]   = tx_ie;
      end
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/console_term_chk.sv
module console_term_chk #(
  parameter int DLY_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [6:0] tx_data,
  input logic       tx_ready,
  input logic       irq_rx,
  input logic       irq_tx
);
  // R1: status bytes carry nothing below the IE bit
  a_r1_status_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0 || reg_sel == 2'd2) |-> (reg_rdata[5:0] == 6'd0));

  // R2: IE cleared on the transmit side drops its request
  a_r2_ie_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && !reg_wdata[6]) |=> !irq_tx);

  // R5: a data read with no arrival leaves no receive request
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd1 && !(rx_valid && rx_ready)) |=> !irq_rx);

  // R6: loading the transmit buffer drops the request and any offer
  a_r6_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3) |=> (!irq_tx && !tx_valid));

  // R7: an unaccepted offer holds steady unless a restart intervenes
  a_r7_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(reg_wr && reg_sel == 2'd3)) |=> (tx_valid && $stable(tx_data)));
endmodule

bind console_term console_term_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/tb_console_term.sv
`timescale 1ns/1ps
module tb_console_term;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [DW-1:0] send_delay = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic rx_ready, tx_valid, tx_ready = 1'b1, irq_rx, irq_tx;
  logic [6:0] tx_data;

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  console_term #(.DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .send_delay(send_delay),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // ---------------- behavioural reference ----------------
  bit m_rrdy = 0, m_rdone = 0, m_rie = 0, m_rirq = 0;
  int m_rbuf = 0;
  bit m_tdone = 1, m_tie = 0, m_tirq = 0;
  int m_tbuf = 0, m_tphase = 0, m_tleft = 0; // phase 0 idle, 1 waiting, 2 offering

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rrdy = 0; m_rdone = 0; m_rie = 0; m_rirq = 0; m_rbuf = 0;
      m_tdone = 1; m_tie = 0; m_tirq = 0; m_tbuf = 0; m_tphase = 0; m_tleft = 0;
    end else begin
      bit arrive, rd_d, w_rs, w_ts, w_td, took, fin, ie_new;
      arrive = m_rrdy && rx_valid;
      rd_d = reg_rd && reg_sel == 2'd1;
      w_rs = reg_wr && reg_sel == 2'd0;
      w_ts = reg_wr && reg_sel == 2'd2;
      w_td = reg_wr && reg_sel == 2'd3;
      // receive side
      if (rd_d) m_rirq = 0;
      if (w_rs) begin
        if (!reg_wdata[6]) m_rirq = 0;
        else if (!m_rie && m_rdone) m_rirq = 1;
      end
      ie_new = w_rs ? reg_wdata[6] : m_rie;
      if (arrive && ie_new) m_rirq = 1;
      m_rie = ie_new;
      if (arrive) begin m_rdone = 1; m_rbuf = rx_data; end
      else if (rd_d) m_rdone = 0;
      m_rrdy = 1;
      // transmit side
      took = (m_tphase == 2) && tx_ready;
      fin = took && !w_td;
      if (w_td) m_tirq = 0;
      if (w_ts) begin
        if (!reg_wdata[6]) m_tirq = 0;
        else if (!m_tie && m_tdone) m_tirq = 1;
      end
      ie_new = w_ts ? reg_wdata[6] : m_tie;
      if (fin && ie_new) m_tirq = 1;
      m_tie = ie_new;
      if (fin) m_tdone = 1; else if (w_td) m_tdone = 0;
      if (w_td) begin m_tphase = 1; m_tleft = send_delay; m_tbuf = reg_wdata & 8'h7f; end
      else if (m_tphase == 1) begin
        if (m_tleft == 0) m_tphase = 2; else m_tleft--;
      end else if (took) m_tphase = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int er;
    case (reg_sel)
      2'd0: er = {m_rdone, m_rie, 6'd0};
      2'd1: er = m_rbuf;
      2'd2: er = {m_tdone, m_tie, 6'd0};
      default: er = 0;
    endcase
    chk("R1 reg_rdata", reg_rdata, er);
    chk("R3 rx_ready", rx_ready, m_rrdy);
    chk("R3 irq_rx", irq_rx, m_rirq);
    chk("R7 irq_tx", irq_tx, m_tirq);
    chk("R6 tx_valid", tx_valid, m_tphase == 2);
    if (m_tphase == 2) chk("R6 tx_data", tx_data, m_tbuf);
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(posedge clk); #2; endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    tick(); reg_sel = s; reg_wdata = d; reg_wr = 1;
    tick(); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s);
    tick(); reg_sel = s; reg_rd = 1;
    tick(); reg_rd = 0;
  endtask

  task automatic rx_put(input logic [7:0] d);
    tick(); rx_valid = 1; rx_data = d;
    tick(); rx_valid = 0;
  endtask

  task automatic peek(input logic [1:0] s, input int exp, input string tag);
    tick(); reg_sel = s;
    @(negedge clk); chk(tag, reg_rdata, exp);
  endtask

  task automatic send(input logic [7:0] d, input int dly);
    int n;
    send_delay = dly[DW-1:0];
    wr(2'd3, d);
    n = 0;
    while (!tx_valid && n < 40) begin @(negedge clk); if (!tx_valid) n++; end
    chk("R6 wait cycles", n, dly + 1);
    chk("R6 low seven bits", tx_data, d & 8'h7f);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    chk("R9 rx_ready in reset", rx_ready, 0);
    rst_n = 1;
    peek(2'd0, 8'h00, "R9 rx status");
    peek(2'd1, 8'h00, "R9 rx buffer");
    peek(2'd2, 8'h80, "R9 tx status");
    chk("R9 irqs", {irq_rx, irq_tx}, 0);

    // R3 receive with IE off
    rx_put(8'hA5);
    peek(2'd0, 8'h80, "R3 rx done");
    chk("R3 no irq with IE off", irq_rx, 0);
    peek(2'd1, 8'hA5, "R3 rx byte");
    // R2 late enable raises the request
    wr(2'd0, 8'h40);
    @(negedge clk); chk("R2 late IE raises", irq_rx, 1);
    // R5 read clears
    rd(2'd1);
    @(negedge clk); chk("R5 read clears irq", irq_rx, 0);
    peek(2'd0, 8'h40, "R5 read clears done");
    // R4 overwrite
    rx_put(8'h11); rx_put(8'h22);
    peek(2'd1, 8'h22, "R4 overwrite");
    peek(2'd0, 8'hC0, "R4 status");
    wr(2'd0, 8'h40);
    @(negedge clk); chk("R2 IE rewrite keeps irq", irq_rx, 1);
    wr(2'd0, 8'h00);
    @(negedge clk); chk("R2 IE off clears", irq_rx, 0);
    wr(2'd1, 8'h55);
    peek(2'd1, 8'h22, "R1 rx data write ignored");
    wr(2'd0, 8'hFF);
    peek(2'd0, 8'hC0, "R1 status write only IE");
    // R5 arrival wins over read
    tick(); reg_sel = 2'd1; reg_rd = 1; rx_valid = 1; rx_data = 8'h9C;
    tick(); reg_rd = 0; rx_valid = 0;
    peek(2'd0, 8'hC0, "R5 arrival wins");
    peek(2'd1, 8'h9C, "R5 arrival byte");
    rd(2'd1);

    // transmit
    wr(2'd2, 8'h40);
    @(negedge clk); chk("R2 tx late IE", irq_tx, 1);
    send(8'hC1, 3);
    repeat (2) @(negedge clk);
    chk("R7 done irq", irq_tx, 1);
    peek(2'd2, 8'hC0, "R7 tx done");
    for (int d = 0; d < 16; d += 5) send(8'h30 + d[7:0], d);
    send(8'h5A, 15);
    // R7 back-pressure
    tx_ready = 0;
    send(8'h7E, 0);
    repeat (5) @(negedge clk);
    chk("R7 held valid", tx_valid, 1);
    chk("R7 held data", tx_data, 7'h7E);
    peek(2'd2, 8'h40, "R7 not done while stalled");
    tick(); tx_ready = 1;
    repeat (2) @(negedge clk);
    peek(2'd2, 8'hC0, "R7 done after take");
    // R8 restart during offer and during wait
    tx_ready = 0;
    send(8'h31, 2);
    send(8'h32, 1);
    send_delay = 4'd6; wr(2'd3, 8'h33);
    send(8'h34, 0);
    tick(); tx_ready = 1;
    // R8 write coincident with handshake
    tx_ready = 0;
    send(8'h45, 1);
    tick(); tx_ready = 1; reg_sel = 2'd3; reg_wdata = 8'h46; send_delay = 4'd2; reg_wr = 1;
    tick(); reg_wr = 0;
    peek(2'd2, 8'h40, "R8 write beats handshake");
    repeat (8) tick();
    // R9 reset mid-send with pending receive
    rx_put(8'h77);
    send_delay = 4'd9; wr(2'd3, 8'h12);
    tick(); rst_n = 0;
    @(negedge clk);
    chk("R9 tx_valid", tx_valid, 0);
    chk("R9 rx_ready", rx_ready, 0);
    tick(); rst_n = 1;
    peek(2'd0, 8'h00, "R9 rx status after reset");
    peek(2'd1, 8'h00, "R9 rx buffer after reset");
    peek(2'd2, 8'h80, "R9 tx status after reset");
    repeat (15) @(negedge clk);
    chk("R9 send cancelled", tx_valid, 0);
    rx_put(8'h3C);
    peek(2'd1, 8'h3C, "R3 receive after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule